// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular queue of eight result slots. It lets instructions finish execution in any order while their effects on architectural state happen strictly in program order. The front end dispatches an instruction with its PC and destination register number. The block answers in the same cycle with the slot tag that the execution units later quote. An execution unit's writeback names a tag and delivers a result value, a fault flag and a mispredict flag. The slot then counts as complete.

The oldest slot is acted on only once it is complete. A clean result is presented for the architectural register file and the slot is released. A faulting result discards every slot, including the faulting one, reports that instruction's PC, and steers fetch to a fixed handler address. A branch whose writeback flagged a mispredict retires normally, carrying its corrected target as its value. It then discards every younger slot and steers fetch to that target. Mispredicts and faults recorded on younger slots therefore have no effect until those slots reach the head.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the queue is empty: `dispatch_ready` is 1, `dispatch_tag` is 0, and `retire_valid`, `exc_valid` and `flush` are 0.
- R2: `dispatch_tag` shows the slot the next dispatch will take. Tags are handed out as 0,1,...,7 in order. A dispatch is accepted at a rising edge only while `dispatch_valid` and `dispatch_ready` are both 1. `dispatch_ready` is 0 while eight slots are held and in any cycle where `flush` is 1.
- R3: A writeback may target held slots in any order and stores value, fault and mispredict for the slot named by `wb_tag`. A writeback to a slot that is not held is dropped, and a later instance in that slot does not inherit it.
- R4: A slot retires only when it is the oldest held slot and complete. Retirements follow dispatch order even when writebacks arrive out of order. A younger complete slot never retires before an incomplete older one.
- R5: When the oldest slot is complete without a fault, `retire_valid` is 1 in the cycle after its writeback edge, with that slot's destination on `retire_dest` and its value on `retire_value`. The slot is released at the next edge.
- R6: When the oldest slot is complete with its fault flag set, `exc_valid` and `flush` are 1 and `retire_valid` is 0. `exc_pc` carries that slot's PC and `redirect_pc` carries the handler address. At the next edge every slot is discarded, the faulting slot included, and `dispatch_tag` returns to the faulting slot's index.
- R7: A mispredict flag takes effect only at the head. A mispredicted oldest slot shows `retire_valid` and `flush` together, with `redirect_pc` equal to its written value. At the next edge all younger slots are discarded, and `dispatch_tag` becomes the index after the branch.
- R8: A dispatch and a retirement in the same cycle both take effect.
- R9: Tags wrap from 7 back to 0. Once a slot is released from a full queue, `dispatch_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dispatch_valid | input | 1 | Dispatch request |
| dispatch_pc | input | 32 | PC of the dispatched instruction |
| dispatch_dest | input | 5 | Destination register number |
| dispatch_ready | output | 1 | Queue can accept a dispatch this cycle |
| dispatch_tag | output | 3 | Slot tag for the dispatch this cycle |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | 3 | Slot addressed by the writeback |
| wb_value | input | 32 | Result value, or corrected target for a mispredicted branch |
| wb_fault | input | 1 | Instruction raised a fault |
| wb_mispredict | input | 1 | Branch was mispredicted |
| retire_valid | output | 1 | Oldest slot commits this cycle |
| retire_dest | output | 5 | Destination register of the committing slot |
| retire_value | output | 32 | Value written to the architectural register file |
| exc_valid | output | 1 | Oldest slot faults this cycle |
| exc_pc | output | 32 | PC of the faulting instruction |
| flush | output | 1 | Discard pulse, one cycle |
| redirect_pc | output | 32 | New fetch address while `flush` is 1 |

## Verification
`dispatch_tag` and `dispatch_ready` are combinational, so they are read before the edge that accepts the dispatch. Head outputs (`retire_valid`, `exc_valid`, `flush` and their data) appear just after the edge that captures a writeback to the oldest slot. The discard they order becomes visible on `dispatch_tag` one edge later. The bench changes inputs 1 ns after each rising edge and reads outputs before the next one. Each check therefore lands in the cycle these counts predict. Squashed slots are shown never to retire by counting retirements over the following cycles.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int ROB_DEPTH = 8;
    localparam int TAG_W     = $clog2(ROB_DEPTH);
    localparam int PTR_W     = TAG_W + 1;
    localparam int REG_W     = 5;
    localparam int DATA_W    = 32;
    localparam int PC_W      = 32;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [PTR_W-1:0] ptr_t;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] value;
        logic              fault;
        logic              mispred;
        logic              done;
    } rob_entry_t;

    function automatic tag_t ptr_idx(input ptr_t p);
        return p[TAG_W-1:0];
    endfunction

    // Same slot index but opposite lap bit: the tail has lapped the head.
    function automatic logic ptr_full(input ptr_t h, input ptr_t t);
        return (h[TAG_W-1:0] == t[TAG_W-1:0]) && (h[TAG_W] != t[TAG_W]);
    endfunction
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr
    import rob_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic load,
    input  ptr_t load_val,
    output ptr_t ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (step)
            ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_en,
    input  tag_t              alloc_tag,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic              wb_en,
    input  tag_t              wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_fault,
    input  logic              wb_mispred,
    input  logic              free_en,
    input  tag_t              free_tag,
    input  logic              clear_all,
    input  tag_t              rd_tag,
    output rob_entry_t        rd_entry,
    output logic              rd_valid
);
    rob_entry_t           slots [ROB_DEPTH];
    logic [ROB_DEPTH-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            for (int i = 0; i < ROB_DEPTH; i++)
                slots[i] <= '0;
        end else begin
            for (int i = 0; i < ROB_DEPTH; i++) begin
                if (clear_all)
                    held[i] <= 1'b0;
                else if (alloc_en && alloc_tag == tag_t'(i))
                    held[i] <= 1'b1;
                else if (free_en && free_tag == tag_t'(i))
                    held[i] <= 1'b0;

                if (alloc_en && alloc_tag == tag_t'(i)) begin
                    slots[i].pc      <= alloc_pc;
                    slots[i].dest    <= alloc_dest;
                    slots[i].value   <= '0;
                    slots[i].fault   <= 1'b0;
                    slots[i].mispred <= 1'b0;
                    slots[i].done    <= 1'b0;
                end else if (wb_en && wb_tag == tag_t'(i) && held[i]) begin
                    slots[i].value   <= wb_value;
                    slots[i].fault   <= wb_fault;
                    slots[i].mispred <= wb_mispred;
                    slots[i].done    <= 1'b1;
                end
            end
        end
    end

    assign rd_entry = slots[rd_tag];
    assign rd_valid = held[rd_tag];

    // A freshly allocated slot must not look complete.
    AST_ALLOC_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        alloc_en |=> !slots[$past(alloc_tag)].done); // R4
endmodule

// File: rtl/rob_retire.sv
module rob_retire
    import rob_pkg::*;
#(
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
)(
    input  rob_entry_t      head,
    input  logic            head_live,
    output logic            commit,
    output logic            fault_go,
    output logic            flush_go,
    output logic [PC_W-1:0] redirect
);
    logic ready;

    always_comb begin
        ready    = head_live && head.done;
        commit   = ready && !head.fault;
        fault_go = ready && head.fault;
        flush_go = fault_go || (commit && head.mispred);
        redirect = fault_go ? HANDLER_PC : head.value;
    end
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
    import rob_pkg::*;
#(
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              dispatch_valid,
    input  logic [PC_W-1:0]   dispatch_pc,
    input  logic [REG_W-1:0]  dispatch_dest,
    output logic              dispatch_ready,
    output logic [TAG_W-1:0]  dispatch_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_fault,
    input  logic              wb_mispredict,
    output logic              retire_valid,
    output logic [REG_W-1:0]  retire_dest,
    output logic [DATA_W-1:0] retire_value,
    output logic              exc_valid,
    output logic [PC_W-1:0]   exc_pc,
    output logic              flush,
    output logic [PC_W-1:0]   redirect_pc
);
    ptr_t       head_ptr, tail_ptr, tail_restart;
    rob_entry_t head_ent;
    logic       head_live, commit, fault_go, flush_go;
    logic       full, alloc, wb_take;

    assign full           = ptr_full(head_ptr, tail_ptr);
    assign dispatch_ready = !full && !flush_go;
    assign alloc          = dispatch_valid && dispatch_ready;
    assign wb_take        = wb_valid && !flush_go;
    // Fault: drop the head too. Mispredict: keep the branch, drop the rest.
    assign tail_restart   = fault_go ? head_ptr : ptr_t'(head_ptr + 1'b1);

    rob_ptr u_head (
        .clk(clk), .rst(rst), .step(commit), .load(1'b0),
        .load_val(head_ptr), .ptr(head_ptr)
    );

    rob_ptr u_tail (
        .clk(clk), .rst(rst), .step(alloc), .load(flush_go),
        .load_val(tail_restart), .ptr(tail_ptr)
    );

    rob_store u_store (
        .clk(clk), .rst(rst),
        .alloc_en(alloc), .alloc_tag(ptr_idx(tail_ptr)),
        .alloc_pc(dispatch_pc), .alloc_dest(dispatch_dest),
        .wb_en(wb_take), .wb_tag(wb_tag), .wb_value(wb_value),
        .wb_fault(wb_fault), .wb_mispred(wb_mispredict),
        .free_en(commit), .free_tag(ptr_idx(head_ptr)),
        .clear_all(flush_go),
        .rd_tag(ptr_idx(head_ptr)), .rd_entry(head_ent), .rd_valid(head_live)
    );

    rob_retire #(.HANDLER_PC(HANDLER_PC)) u_retire (
        .head(head_ent), .head_live(head_live),
        .commit(commit), .fault_go(fault_go), .flush_go(flush_go),
        .redirect(redirect_pc)
    );

    assign dispatch_tag = ptr_idx(tail_ptr);
    assign retire_valid = commit;
    assign retire_dest  = head_ent.dest;
    assign retire_value = head_ent.value;
    assign exc_valid    = fault_go;
    assign exc_pc       = head_ent.pc;
    assign flush        = flush_go;

    AST_FULL_TAIL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && !flush_go) |=> tail_ptr == $past(tail_ptr)); // R2
    AST_RETIRE_STEPS: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && !flush) |=> head_ptr == ptr_t'($past(head_ptr) + 1'b1)); // R4
    AST_FAULT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (tail_ptr == head_ptr) && (head_ptr == $past(head_ptr))); // R6
    AST_MISP_SQUASH: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && flush) |=> (tail_ptr == head_ptr) &&
            (head_ptr == ptr_t'($past(head_ptr) + 1'b1))); // R7
    AST_NO_DUAL_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> !retire_valid && flush); // R6
endmodule

// File: tb/reorder_buffer_tb.sv
`timescale 1ns/1ps
module reorder_buffer_tb;
    localparam logic [31:0] HANDLER = 32'h0000_0800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dispatch_valid = 1'b0;
    logic [31:0] dispatch_pc = '0;
    logic [4:0]  dispatch_dest = '0;
    logic        dispatch_ready;
    logic [2:0]  dispatch_tag;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [31:0] wb_value = '0;
    logic        wb_fault = 1'b0;
    logic        wb_mispredict = 1'b0;
    logic        retire_valid;
    logic [4:0]  retire_dest;
    logic [31:0] retire_value;
    logic        exc_valid;
    logic [31:0] exc_pc;
    logic        flush;
    logic [31:0] redirect_pc;

    int n_chk = 0;
    int n_err = 0;
    int n_ret = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    reorder_buffer #(.HANDLER_PC(HANDLER)) u_dut (
        .clk(clk), .rst(rst),
        .dispatch_valid(dispatch_valid), .dispatch_pc(dispatch_pc),
        .dispatch_dest(dispatch_dest), .dispatch_ready(dispatch_ready),
        .dispatch_tag(dispatch_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
        .wb_fault(wb_fault), .wb_mispredict(wb_mispredict),
        .retire_valid(retire_valid), .retire_dest(retire_dest),
        .retire_value(retire_value), .exc_valid(exc_valid), .exc_pc(exc_pc),
        .flush(flush), .redirect_pc(redirect_pc)
    );

    // Count retirements once per cycle, mid-cycle.
    always @(negedge clk)
        if (!rst && retire_valid) n_ret++;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; dispatch_valid = 1'b0; wb_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic disp(input logic [31:0] pc, input logic [4:0] dst,
                        output logic [2:0] tag);
        dispatch_valid = 1'b1; dispatch_pc = pc; dispatch_dest = dst;
        #1 tag = dispatch_tag;
        @(posedge clk); #1;
        dispatch_valid = 1'b0;
    endtask

    task automatic wb(input logic [2:0] tag, input logic [31:0] val,
                      input logic f, input logic m);
        wb_valid = 1'b1; wb_tag = tag; wb_value = val;
        wb_fault = f; wb_mispredict = m;
        @(posedge clk); #1;
        wb_valid = 1'b0; wb_fault = 1'b0; wb_mispredict = 1'b0;
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1", "ready", 32'(dispatch_ready), 1);
        chk("R1", "tag", 32'(dispatch_tag), 0);
        chk("R1", "retire", 32'(retire_valid), 0);
        chk("R1", "exc", 32'(exc_valid), 0);
        chk("R1", "flush", 32'(flush), 0);
    endtask

    task automatic test_out_of_order();
        logic [2:0] t;
        int base;
        do_reset();
        disp(32'h100, 5'd1, t); chk("R2", "tag0", 32'(t), 0);
        disp(32'h104, 5'd2, t); chk("R2", "tag1", 32'(t), 1);
        disp(32'h108, 5'd3, t); chk("R2", "tag2", 32'(t), 2);
        wb(3'd2, 32'h33, 1'b0, 1'b0);
        chk("R4", "young done, head not", 32'(retire_valid), 0);
        wb(3'd1, 32'h22, 1'b0, 1'b0);
        chk("R4", "head still pending", 32'(retire_valid), 0);
        wb(3'd0, 32'h11, 1'b0, 1'b0);
        chk("R5", "retire0", 32'(retire_valid), 1);
        chk("R5", "dest0", 32'(retire_dest), 1);
        chk("R5", "val0", retire_value, 32'h11);
        tick();
        chk("R4", "dest1", 32'(retire_dest), 2);
        chk("R4", "val1", retire_value, 32'h22);
        tick();
        chk("R4", "dest2", 32'(retire_dest), 3);
        chk("R4", "val2", retire_value, 32'h33);
        tick();
        chk("R4", "drained", 32'(retire_valid), 0);
        chk("R2", "tail3", 32'(dispatch_tag), 3);
        // stray writeback to a slot nobody holds
        wb(3'd6, 32'hDEAD, 1'b0, 1'b0);
        base = n_ret;
        disp(32'h10C, 5'd4, t);
        disp(32'h110, 5'd5, t);
        disp(32'h114, 5'd6, t);
        disp(32'h118, 5'd7, t); chk("R2", "tag6", 32'(t), 6);
        repeat (3) tick();
        chk("R3", "stray wb ignored, nothing retires", 32'(n_ret - base), 0);
        wb(3'd3, 32'h44, 1'b0, 1'b0);
        wb(3'd4, 32'h55, 1'b0, 1'b0);
        wb(3'd5, 32'h56, 1'b0, 1'b0);
        wb(3'd6, 32'h66, 1'b0, 1'b0);
        chk("R3", "slot6 dest", 32'(retire_dest), 7);
        chk("R3", "slot6 value", retire_value, 32'h66);
    endtask

    task automatic test_full_wrap();
        logic [2:0] t;
        int base;
        do_reset();
        base = n_ret;
        for (int i = 0; i < 8; i++) begin
            disp(32'h400 + 32'(i * 4), 5'(i + 8), t);
            chk("R2", "fill tag", 32'(t), 32'(i));
        end
        chk("R2", "full not ready", 32'(dispatch_ready), 0);
        dispatch_valid = 1'b1; dispatch_pc = 32'h4F0; dispatch_dest = 5'd30;
        tick();
        dispatch_valid = 1'b0;
        chk("R2", "blocked dispatch, tag unchanged", 32'(dispatch_tag), 0);
        wb(3'd0, 32'h5, 1'b0, 1'b0);
        chk("R9", "retire from full", 32'(retire_valid), 1);
        tick();
        chk("R9", "ready after release", 32'(dispatch_ready), 1);
        disp(32'h500, 5'd31, t);
        chk("R9", "wrapped tag", 32'(t), 0);
        chk("R2", "full again", 32'(dispatch_ready), 0);
        for (int i = 1; i < 8; i++) wb(3'(i), 32'(i), 1'b0, 1'b0);
        wb(3'd0, 32'h99, 1'b0, 1'b0);
        chk("R9", "wrapped slot value", retire_value, 32'h99);
        repeat (2) tick();
        chk("R4", "all retired", 32'(n_ret - base), 9);
        chk("R9", "tag after lap", 32'(dispatch_tag), 1);
    endtask

    task automatic test_same_cycle();
        logic [2:0] t;
        do_reset();
        disp(32'h600, 5'd4, t);
        wb(3'd0, 32'h40, 1'b0, 1'b0);
        chk("R8", "retire present", 32'(retire_valid), 1);
        chk("R8", "ready with retire", 32'(dispatch_ready), 1);
        disp(32'h604, 5'd5, t);
        chk("R8", "tag during retire", 32'(t), 1);
        chk("R8", "head moved on", 32'(retire_valid), 0);
        chk("R8", "tail advanced", 32'(dispatch_tag), 2);
        wb(3'd1, 32'h50, 1'b0, 1'b0);
        chk("R8", "second dest", 32'(retire_dest), 5);
        chk("R8", "second value", retire_value, 32'h50);
    endtask

    task automatic test_fault();
        logic [2:0] t;
        int base;
        do_reset();
        disp(32'h200, 5'd6, t);
        disp(32'h204, 5'd7, t);
        disp(32'h208, 5'd8, t);
        wb(3'd1, 32'h1, 1'b0, 1'b0);
        wb(3'd2, 32'h2, 1'b0, 1'b0);
        chk("R4", "no retire before head", 32'(retire_valid), 0);
        wb(3'd0, 32'h0, 1'b1, 1'b0);
        base = n_ret;
        chk("R6", "exc", 32'(exc_valid), 1);
        chk("R6", "exc_pc", exc_pc, 32'h200);
        chk("R6", "flush", 32'(flush), 1);
        chk("R6", "redirect", redirect_pc, HANDLER);
        chk("R6", "no retire", 32'(retire_valid), 0);
        chk("R2", "not ready in flush", 32'(dispatch_ready), 0);
        tick();
        chk("R6", "exc pulse", 32'(exc_valid), 0);
        chk("R6", "flush pulse", 32'(flush), 0);
        chk("R6", "tag back to head", 32'(dispatch_tag), 0);
        chk("R6", "ready", 32'(dispatch_ready), 1);
        repeat (3) tick();
        chk("R6", "squashed never retire", 32'(n_ret - base), 0);
    endtask

    task automatic test_mispredict();
        logic [2:0] t;
        int base;
        do_reset();
        disp(32'h300, 5'd9, t);
        disp(32'h304, 5'd10, t);
        disp(32'h308, 5'd11, t);
        wb(3'd2, 32'h77, 1'b0, 1'b0);
        wb(3'd1, 32'h2000, 1'b0, 1'b1);
        chk("R7", "no flush off head", 32'(flush), 0);
        wb(3'd0, 32'h12, 1'b0, 1'b0);
        chk("R7", "older retires", 32'(retire_valid), 1);
        chk("R7", "older no flush", 32'(flush), 0);
        tick();
        base = n_ret;
        chk("R7", "branch retires", 32'(retire_valid), 1);
        chk("R7", "branch dest", 32'(retire_dest), 10);
        chk("R7", "branch value", retire_value, 32'h2000);
        chk("R7", "flush", 32'(flush), 1);
        chk("R7", "redirect", redirect_pc, 32'h2000);
        chk("R7", "no exc", 32'(exc_valid), 0);
        tick();
        chk("R7", "flush pulse", 32'(flush), 0);
        chk("R7", "tag after branch", 32'(dispatch_tag), 2);
        repeat (2) tick();
        chk("R7", "younger squashed", 32'(n_ret - base), 1);
    endtask

    initial begin
        test_reset();
        test_out_of_order();
        test_full_wrap();
        test_same_cycle();
        test_fault();
        test_mispredict();
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule